// File: doc/BRIEF.md
# Power Button and Alarm Wake Status Logic

This block keeps the 8-bit power-management status byte that records three hardware events: a press of the front-panel power button, a real-time-clock alarm, and a button override, which is a press held long enough to force the machine off. Hardware sets each status flag. Software reads the byte through a small I/O read/write port and clears a flag by writing a one to its bit. A battery power-on reset returns the byte to zero.

The status flags drive three outputs:
- An SCI interrupt, raised in the working state when a flag and its enable are both set.
- A wake request, raised in the sleeping and soft-off states when the button flag is set. The button enable does not gate it.
- A soft-off request pulse, issued when the override fires. This pulse tells the power sequencer to release the power-on output.

A 1 Hz tick from elsewhere times the override. An alarm-remember enable lets an alarm that arrives while main standby power is absent still leave its mark in the status byte.

Top module: `pwr_evt_ctrl`

## Requirements
- R1: After reset (`rst_n` low), the status byte is 00h and `sci`, `wake` and `soft_off_req` are low.
- R2: With `reg_addr` = 1, `rd_data` returns the status byte: bit 0 is the button flag, bit 2 is the alarm flag, bit 3 is the override flag. Bits 1 and 4 to 7 always read 0. Any other `reg_addr` reads 00h, and writes to any other address change nothing.
- R3: A write of 1 to a flag's bit position at address 1 clears that flag on the next clock edge. A write of 0 leaves the flag unchanged. If a hardware set and a write-one clear of the same flag fall in the same cycle, the flag ends up set.
- R4: `button_in` passes through a two-flop synchronizer. The button flag is set on a rising edge of the synchronized signal, and it is visible on the third rising clock edge after the input rises. Holding the button at its level does not set the flag again after a clear.
- R5: In the working state (`pwr_state` = 00), `sci` equals (`btn_en` AND button flag) OR (`rtc_en` AND alarm flag). In any other state, `sci` is low.
- R6: In the sleeping state (`pwr_state` = 01) and the soft-off state (`pwr_state` = 10), `wake` equals the button flag whatever the value of `btn_en`. In the working state, `wake` is low.
- R7: With `ovr_en` high, the override fires on the edge where a `tick_1hz` pulse arrives while the synchronized button has already been held through HOLD_TICKS earlier ticks. HOLD_TICKS is 4 by default, so the override fires on the 5th tick. On that edge the button flag clears, the override flag sets, and `soft_off_req` pulses high for exactly one cycle.
- R8: The override fires at most once per press. Releasing the button restarts the tick count. If `ovr_en` is low on the deciding tick, that press does not fire.
- R9: A one-cycle `rtc_alarm` pulse sets the alarm flag on the next edge when `stby_pwr_ok` is high. When `stby_pwr_ok` is low, the pulse sets the flag only if `alarm_keep_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low battery power-on reset |
| button_in | input | 1 | Asynchronous power button, high when pressed |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| rtc_alarm | input | 1 | One-cycle alarm event pulse from the clock |
| stby_pwr_ok | input | 1 | Main standby power present |
| alarm_keep_en | input | 1 | Record alarms that arrive while standby power is absent |
| btn_en | input | 1 | Button SCI enable |
| rtc_en | input | 1 | Alarm SCI enable |
| ovr_en | input | 1 | Button override enable |
| pwr_state | input | 2 | 00 working, 01 sleeping, 10 soft-off |
| reg_addr | input | 2 | Register offset within the block |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `reg_addr` |
| sci | output | 1 | SCI interrupt request |
| wake | output | 1 | Wake event request |
| soft_off_req | output | 1 | One-cycle soft-off request |

## Verification
Each result has a fixed latency:
- A button press shows in the status byte on the third rising edge after the input changes, which covers two synchronizer flops and the status register.
- An alarm pulse or a clearing write takes effect on the first edge.
- The override result and `soft_off_req` appear on the edge that takes the deciding tick.
- `sci`, `wake` and `rd_data` follow the status and the inputs in the same cycle.

The bench drives all inputs on the falling edge and advances a counted number of rising edges. It samples on the next falling edge, so each check reads the cycle the latency predicts. The one-cycle pulse check reads both that cycle and the one after it.

// File: rtl/pwr_evt_pkg.sv
package pwr_evt_pkg;

  typedef enum logic [1:0] {
    PS_WORK    = 2'b00,
    PS_SLEEP   = 2'b01,
    PS_SOFTOFF = 2'b10
  } pstate_e;

  // Bit positions decoded by software in the status byte
  localparam int BTN_BIT = 0;
  localparam int RTC_BIT = 2;
  localparam int OVR_BIT = 3;

  // Next value of a write-one-to-clear flag; hardware set wins
  function automatic logic flag_next(logic cur, logic hw_set, logic sw_clr);
    return hw_set | (cur & ~sw_clr);
  endfunction

  // Assemble the status byte; reserved positions stay zero
  function automatic logic [7:0] sts_pack(logic btn, logic rtc, logic ovr);
    logic [7:0] v;
    v = 8'h00;
    v[BTN_BIT] = btn;
    v[RTC_BIT] = rtc;
    v[OVR_BIT] = ovr;
    return v;
  endfunction

endpackage

// File: rtl/pwr_btn_sync.sv
module pwr_btn_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic btn_async,
  output logic btn_held,
  output logic btn_rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= btn_async;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign btn_held = sync_q;
  assign btn_rise = sync_q & ~prev_q;

  // R4
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    btn_rise |=> !btn_rise);
endmodule

// File: rtl/pwr_hold_timer.sv
module pwr_hold_timer #(
  parameter int HOLD_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic held,
  input  logic tick,
  input  logic arm,
  output logic fire
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 2);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS);
  localparam logic [CNT_W-1:0] SAT  = CNT_W'(HOLD_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;

  // Saturating tick count for the current press
  function automatic logic [CNT_W-1:0] cnt_step(logic [CNT_W-1:0] c);
    return (c == SAT) ? c : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!held)     cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_step(cnt_q);
  end

  assign fire = held & tick & arm & (cnt_q == LAST);

  // R8
  once_per_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);
  // R8
  release_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !held |=> (cnt_q == '0));
endmodule

// File: rtl/pwr_sts_reg.sv
module pwr_sts_reg
  import pwr_evt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_btn,
  input  logic kill_btn,
  input  logic set_rtc,
  input  logic set_ovr,
  input  logic clr_btn,
  input  logic clr_rtc,
  input  logic clr_ovr,
  output logic btn_sts,
  output logic rtc_sts,
  output logic ovr_sts
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btn_sts <= 1'b0;
      rtc_sts <= 1'b0;
      ovr_sts <= 1'b0;
    end else begin
      btn_sts <= flag_next(btn_sts & ~kill_btn, set_btn, clr_btn);
      rtc_sts <= flag_next(rtc_sts, set_rtc, clr_rtc);
      ovr_sts <= flag_next(ovr_sts, set_ovr, clr_ovr);
    end
  end

  // R3
  rtc_fall_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtc_sts) |-> $past(clr_rtc));
  // R3
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_rtc |=> rtc_sts);
  // R7
  override_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_ovr |=> (ovr_sts && !btn_sts));
endmodule

// File: rtl/pwr_evt_ctrl.sv
module pwr_evt_ctrl
  import pwr_evt_pkg::*;
#(
  parameter int HOLD_TICKS = 4,
  parameter int ADDR_W     = 2,
  parameter int STS_OFFSET = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              button_in,
  input  logic              tick_1hz,
  input  logic              rtc_alarm,
  input  logic              stby_pwr_ok,
  input  logic              alarm_keep_en,
  input  logic              btn_en,
  input  logic              rtc_en,
  input  logic              ovr_en,
  input  logic [1:0]        pwr_state,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        rd_data,
  output logic              sci,
  output logic              wake,
  output logic              soft_off_req
);
  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(STS_OFFSET);

  logic    btn_held, btn_rise, ovr_fire, sts_hit, alarm_take;
  logic    btn_sts, rtc_sts, ovr_sts, soft_off_q, working;
  logic    unused_wdata;
  pstate_e state;

  assign state        = pstate_e'(pwr_state);
  assign working      = (state == PS_WORK);
  assign sts_hit      = reg_wr & (reg_addr == STS_ADDR);
  assign alarm_take   = rtc_alarm & (stby_pwr_ok | alarm_keep_en);
  assign unused_wdata = ^{reg_wdata[7:4], reg_wdata[1]};

  pwr_btn_sync u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .btn_async(button_in),
    .btn_held (btn_held),
    .btn_rise (btn_rise)
  );

  pwr_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk  (clk),
    .rst_n(rst_n),
    .held (btn_held),
    .tick (tick_1hz),
    .arm  (ovr_en),
    .fire (ovr_fire)
  );

  pwr_sts_reg u_sts (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_btn (btn_rise),
    .kill_btn(ovr_fire),
    .set_rtc (alarm_take),
    .set_ovr (ovr_fire),
    .clr_btn (sts_hit & reg_wdata[BTN_BIT]),
    .clr_rtc (sts_hit & reg_wdata[RTC_BIT]),
    .clr_ovr (sts_hit & reg_wdata[OVR_BIT]),
    .btn_sts (btn_sts),
    .rtc_sts (rtc_sts),
    .ovr_sts (ovr_sts)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) soft_off_q <= 1'b0;
    else        soft_off_q <= ovr_fire;
  end

  assign soft_off_req = soft_off_q;
  assign rd_data      = (reg_addr == STS_ADDR) ? sts_pack(btn_sts, rtc_sts, ovr_sts) : 8'h00;
  assign sci          = working & ((btn_en & btn_sts) | (rtc_en & rtc_sts));
  assign wake         = ~working & btn_sts;

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[1] == 1'b0) && (rd_data[7:4] == 4'h0));
  // R5
  no_sci_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !working |-> !sci);
  // R6
  no_wake_working_chk: assert property (@(posedge clk) disable iff (!rst_n)
    working |-> !wake);
  // R7
  soft_off_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_off_req |=> !soft_off_req);
endmodule

// File: tb/pwr_evt_ctrl_test.sv
module pwr_evt_ctrl_test;
  localparam time CLK_PERIOD = 10;
  localparam int  WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       button_in = 1'b0, tick_1hz = 1'b0, rtc_alarm = 1'b0;
  logic       stby_pwr_ok = 1'b1, alarm_keep_en = 1'b0;
  logic       btn_en = 1'b0, rtc_en = 1'b0, ovr_en = 1'b0;
  logic [1:0] pwr_state = 2'b00;
  logic [1:0] reg_addr = 2'd1;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] rd_data;
  logic       sci, wake, soft_off_req;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_evt_ctrl uut (
    .clk(clk), .rst_n(rst_n), .button_in(button_in), .tick_1hz(tick_1hz),
    .rtc_alarm(rtc_alarm), .stby_pwr_ok(stby_pwr_ok), .alarm_keep_en(alarm_keep_en),
    .btn_en(btn_en), .rtc_en(rtc_en), .ovr_en(ovr_en), .pwr_state(pwr_state),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .rd_data(rd_data), .sci(sci), .wake(wake), .soft_off_req(soft_off_req)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // status byte as software sees it: btn bit0, rtc bit2, ovr bit3
  function automatic logic [7:0] exp_sts(bit b, bit r, bit o);
    return {4'h0, o, r, 1'b0, b};
  endfunction

  task automatic read_sts(output logic [7:0] v);
    reg_addr = 2'd1;
    #1 v = rd_data;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0; reg_addr = 2'd1; reg_wdata = 8'h00;
  endtask

  task automatic tick_once();
    tick_1hz = 1'b1;
    step(1);
    tick_1hz = 1'b0;
  endtask

  task automatic clear_all();
    button_in = 1'b0;
    step(4);
    wr(2'd1, 8'hFF);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    read_sts(v);
    check("R1 status after reset", v, 8'h00);
    check("R1 sci/wake/soft_off after reset", {5'b0, sci, wake, soft_off_req}, 8'h00);
  endtask

  task automatic t_button();
    logic [7:0] v;
    button_in = 1'b1;
    step(2);
    read_sts(v);
    check("R4 not yet set after two edges", v, 8'h00);
    step(1);
    read_sts(v);
    check("R4 set on third edge", v, exp_sts(1, 0, 0));
    wr(2'd1, 8'h01);
    step(3);
    read_sts(v);
    check("R4 held level does not re-set", v, 8'h00);
    clear_all();
  endtask

  task automatic t_map_w1c();
    logic [7:0] v;
    rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
    button_in = 1'b1; step(3);
    read_sts(v);
    check("R2 status map", v, exp_sts(1, 1, 0));
    reg_addr = 2'd0; #1;
    check("R2 other offset reads zero", rd_data, 8'h00);
    wr(2'd2, 8'hFF);
    read_sts(v);
    check("R2 write to other offset ignored", v, exp_sts(1, 1, 0));
    wr(2'd1, 8'h00);
    read_sts(v);
    check("R3 write zero no effect", v, exp_sts(1, 1, 0));
    wr(2'd1, 8'h04);
    read_sts(v);
    check("R3 write one clears only its bit", v, exp_sts(1, 0, 0));
    rtc_alarm = 1'b1; reg_addr = 2'd1; reg_wdata = 8'h04; reg_wr = 1'b1;
    step(1);
    rtc_alarm = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
    read_sts(v);
    check("R3 set wins over same-cycle clear", v, exp_sts(1, 1, 0));
    clear_all();
  endtask

  task automatic t_sci_wake();
    logic [7:0] v;
    button_in = 1'b1; step(3);
    pwr_state = 2'b00; btn_en = 1'b0; #1;
    check("R5 no sci with button enable clear", {7'b0, sci}, 8'h00);
    btn_en = 1'b1; #1;
    check("R5 sci with button enable and status", {7'b0, sci}, 8'h01);
    check("R6 no wake in working state", {7'b0, wake}, 8'h00);
    btn_en = 1'b0; pwr_state = 2'b01; #1;
    check("R6 wake in sleep with enable clear", {7'b0, wake}, 8'h01);
    btn_en = 1'b1; #1;
    check("R5 no sci in sleep", {7'b0, sci}, 8'h00);
    pwr_state = 2'b10; btn_en = 1'b0; #1;
    check("R6 wake in soft-off", {7'b0, wake}, 8'h01);
    pwr_state = 2'b00;
    clear_all();
    read_sts(v);
    check("R3 clear all", v, 8'h00);
    rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
    rtc_en = 1'b1; #1;
    check("R5 sci from alarm with enable", {7'b0, sci}, 8'h01);
    rtc_en = 1'b0; #1;
    check("R5 no sci from alarm without enable", {7'b0, sci}, 8'h00);
    clear_all();
  endtask

  task automatic t_rtc();
    logic [7:0] v;
    stby_pwr_ok = 1'b0; alarm_keep_en = 1'b0;
    rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
    read_sts(v);
    check("R9 alarm dropped without standby and keep", v, 8'h00);
    alarm_keep_en = 1'b1;
    rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
    read_sts(v);
    check("R9 alarm kept without standby", v, exp_sts(0, 1, 0));
    stby_pwr_ok = 1'b1; alarm_keep_en = 1'b0;
    clear_all();
    rtc_alarm = 1'b1; step(1); rtc_alarm = 1'b0;
    read_sts(v);
    check("R9 alarm with standby present", v, exp_sts(0, 1, 0));
    clear_all();
  endtask

  task automatic t_override();
    logic [7:0] v;
    ovr_en = 1'b1;
    button_in = 1'b1; step(3);
    repeat (4) tick_once();
    read_sts(v);
    check("R7 no override after four ticks", v, exp_sts(1, 0, 0));
    check("R7 no soft-off yet", {7'b0, soft_off_req}, 8'h00);
    tick_once();
    read_sts(v);
    check("R7 override on fifth tick", v, exp_sts(0, 0, 1));
    check("R7 soft-off pulse high", {7'b0, soft_off_req}, 8'h01);
    step(1);
    check("R7 soft-off pulse one cycle", {7'b0, soft_off_req}, 8'h00);
    wr(2'd1, 8'h08);
    repeat (3) tick_once();
    read_sts(v);
    check("R8 fires once per press", v, 8'h00);
    check("R8 no second soft-off", {7'b0, soft_off_req}, 8'h00);
    button_in = 1'b0; step(4);
    button_in = 1'b1; step(3);
    repeat (3) tick_once();
    button_in = 1'b0; step(4);
    button_in = 1'b1; step(3);
    repeat (4) tick_once();
    read_sts(v);
    check("R8 release restarts count", v, exp_sts(1, 0, 0));
    ovr_en = 1'b0;
    tick_once();
    read_sts(v);
    check("R8 no override with enable clear", v, exp_sts(1, 0, 0));
    ovr_en = 1'b1;
    repeat (2) tick_once();
    read_sts(v);
    check("R8 missed press stays quiet", v, exp_sts(1, 0, 0));
    ovr_en = 1'b0;
    clear_all();
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_button();
    t_map_w1c();
    t_sci_wake();
    t_rtc();
    t_override();
    finish_run();
  end
endmodule